// File: doc/BRIEF.md
# Power State Sequencer

This block is the synchronous state machine that decides which power state a power management device is in. It steps through eight states: off, cold start, watchdog, on, user-off wait, memory hold, user off and warm start. From the current state it drives the two active-low reset lines (one for the system, one for the MCU), the permission for serial-bus register access, the gate on the interrupt line, the enables of the peripheral and MCU 32 kHz clocks, a vector of regulator enables that switch on one after another, and a warm-boot flag.

All timing is counted in millisecond ticks from a single shared elapsed-time counter. The counter restarts on every state change and advances only in states that have a timer. Two low-power states are available, and each has its own retention and its own wake path. Memory hold wakes through a cold start and sets the warm-boot flag. User off keeps the MCU reset high and wakes through a warm start. Software picks which low-power state to enter by writing a 2-bit target code while register access is permitted.

Top module: `pwr_mode_seq`

## Requirements
- R1: While `rst` is high at a clock edge, the machine goes to off. After that edge both reset lines are low, every other output is 0, and `warm_boot` is 0.
- R2: In off, `turn_on` moves the machine to cold start at the next edge only when `bp_ok` is also high. With `bp_ok` low, `turn_on` has no effect.
- R3: In cold start and warm start, `reg_en[k]` is 1 once the elapsed tick count since entry is at least INIT_MS + k*STEP_MS. At most one regulator turns on per cycle. All regulators are on in watchdog, on and user-off wait. All are off in off, memory hold and user off.
- R4: Cold start holds both resets low, and warm start holds only the system reset low. Either state moves to watchdog once all regulators are on and the elapsed count is at least RST_MS. `wdi` and `stby` have no effect in these states.
- R5: Watchdog drives both resets high and moves to on after WDOG_MS ticks. A low `wdi` there has no effect.
- R6: In on, a low `wdi` sends the machine to the selected low-power target. Otherwise `spi_uoff_req` moves it to user-off wait.
- R7: The target code is written by `spi_lp_wr` only while `spi_en` is 1, and it is reset to 0 in cold start and warm start. Code 1 selects memory hold, code 2 selects user off, and codes 0 and 3 select off. In user-off wait, `wdi` has no effect, and after WAIT_MS ticks the machine goes to the target.
- R8: `spi_en` is 1 exactly in watchdog, on and user-off wait. `int_pass` is 1 exactly in watchdog and on.
- R9: Memory hold drives both resets low and the peripheral clock off. The MCU clock is on only when `cfg_drm` is set. A valid turn-on (`turn_on` with `bp_ok`) goes to cold start and sets `warm_boot`.
- R10: User off drives the system reset low and the MCU reset high, with the peripheral clock off. In user off and in warm start, the MCU clock is on when (`cfg_mcuclk_en` and `cfg_uoffclk`) or `cfg_drm`. A valid turn-on goes to warm start.
- R11: `warm_boot` clears on `spi_wb_clr` only while `spi_en` is 1. Outside those states the strobe has no effect.
- R12: Ticks change the elapsed count only in cold start, warm start, watchdog and user-off wait. Ticks that arrive in off do not shorten the next start-up ramp.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_tick | input | 1 | One-cycle millisecond tick |
| turn_on | input | 1 | Turn-on event |
| bp_ok | input | 1 | Supply above undervoltage threshold |
| wdi | input | 1 | Watchdog input pin |
| stby | input | 2 | Standby pins (ignored by the sequencer) |
| spi_uoff_req | input | 1 | User-off request strobe |
| spi_lp_wr | input | 1 | Low-power target write strobe |
| spi_lp_code | input | 2 | Low-power target code |
| spi_wb_clr | input | 1 | Warm-boot flag clear strobe |
| cfg_mcuclk_en | input | 1 | MCU clock enable bit |
| cfg_uoffclk | input | 1 | Keep MCU clock in user off |
| cfg_drm | input | 1 | MCU clock override bit |
| rst_sys_n | output | 1 | System reset, active low |
| rst_mcu_n | output | 1 | MCU reset, active low |
| spi_en | output | 1 | Register access permitted |
| int_pass | output | 1 | Interrupt line allowed (0 forces it low) |
| clk32_per_en | output | 1 | Peripheral 32 kHz clock enable |
| clk32_mcu_en | output | 1 | MCU 32 kHz clock enable |
| reg_en | output | NREG | Staggered regulator enables |
| warm_boot | output | 1 | Warm-boot status flag |

## Verification
The bench goes after the following corner cases.
- `turn_on` with a low supply flag. A design that skipped the supply check would leave off.
- Ticks that arrive in off before a start. A counter that kept running in off would switch regulators on early.
- A low `wdi` or standby activity during cold start, warm start, watchdog and user-off wait. A design that did not ignore `wdi` there would drop out of start-up too soon.
- A clear strobe sent while register access is blocked. A design that did not gate it would lose the warm-boot flag.
- The eight combinations of the three clock configuration bits in memory hold and user off, to catch a wrong retention term.
- Random traffic that writes target codes, including the codes that map to off, in the same cycle that the wait timer expires. A design that used the new code instead of the previously latched one would pick the wrong low-power state.

// File: rtl/pms_pkg.sv
package pms_pkg;

    typedef enum logic [2:0] {
        PS_OFF     = 3'd0,
        PS_COLD    = 3'd1,
        PS_WDOG    = 3'd2,
        PS_ON      = 3'd3,
        PS_UOWAIT  = 3'd4,
        PS_MEMHOLD = 3'd5,
        PS_USEROFF = 3'd6,
        PS_WARM    = 3'd7
    } pstate_t;

    typedef struct packed {
        logic rst_sys_n;
        logic rst_mcu_n;
        logic spi_en;
        logic int_pass;
        logic clk_per;
        logic clk_mcu;
    } pout_t;

    typedef struct packed {
        logic mcu_en;
        logic uoff_clk;
        logic drm;
    } clkcfg_t;

    function automatic logic is_ramp(pstate_t s);
        return (s == PS_COLD) || (s == PS_WARM);
    endfunction

    function automatic logic is_powered(pstate_t s);
        return (s == PS_WDOG) || (s == PS_ON) || (s == PS_UOWAIT);
    endfunction

    function automatic logic is_timed(pstate_t s);
        return is_ramp(s) || (s == PS_WDOG) || (s == PS_UOWAIT);
    endfunction

    function automatic pstate_t lp_dest(logic [1:0] code);
        case (code)
            2'd1:    return PS_MEMHOLD;
            2'd2:    return PS_USEROFF;
            default: return PS_OFF;
        endcase
    endfunction

    function automatic pout_t decode_out(pstate_t s, clkcfg_t c);
        pout_t o;
        logic  pw;
        logic  keep;
        pw          = is_powered(s);
        keep        = (c.mcu_en & c.uoff_clk) | c.drm;
        o.rst_sys_n = pw;
        o.rst_mcu_n = pw | (s == PS_USEROFF) | (s == PS_WARM);
        o.spi_en    = pw;
        o.int_pass  = (s == PS_WDOG) | (s == PS_ON);
        o.clk_per   = pw;
        o.clk_mcu   = pw | ((s == PS_MEMHOLD) & c.drm)
                    | (((s == PS_USEROFF) | (s == PS_WARM)) & keep);
        return o;
    endfunction

endpackage

// File: rtl/pms_timer.sv
module pms_timer #(
    parameter int TW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          restart,
    input  logic          run,
    input  logic          tick,
    output logic [TW-1:0] elapsed
);
    always_ff @(posedge clk) begin
        if (rst || restart)
            elapsed <= '0;
        else if (run && tick && !(&elapsed))
            elapsed <= elapsed + 1'b1;
    end

    // R12
    timer_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(restart) && !$past(rst)) |-> (elapsed - $past(elapsed)) <= TW'(1));
endmodule

// File: rtl/pms_stagger.sv
module pms_stagger #(
    parameter int NREG    = 4,
    parameter int INIT_MS = 8,
    parameter int STEP_MS = 1,
    parameter int TW      = 5
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ramp,
    input  logic            powered,
    input  logic [TW-1:0]   elapsed,
    output logic [NREG-1:0] reg_en,
    output logic            all_up
);
    for (genvar k = 0; k < NREG; k++) begin : g_rail
        localparam logic [TW-1:0] ON_AT = TW'(INIT_MS + k * STEP_MS);
        assign reg_en[k] = powered | (ramp & (elapsed >= ON_AT));
    end

    assign all_up = &reg_en;

    // R3
    one_rail_per_cycle_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(reg_en) <= $countones($past(reg_en)) + 1);
endmodule

// File: rtl/pms_fsm.sv
module pms_fsm
    import pms_pkg::*;
#(
    parameter int TW      = 5,
    parameter int RST_MS  = 12,
    parameter int WDOG_MS = 16,
    parameter int WAIT_MS = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          turn_on,
    input  logic          bp_ok,
    input  logic          wdi,
    input  logic          uoff_req,
    input  logic          lp_wr,
    input  logic [1:0]    lp_code,
    input  logic          wb_clr,
    input  clkcfg_t       ccfg,
    input  logic [TW-1:0] elapsed,
    input  logic          all_up,
    output pstate_t       cur,
    output logic          restart,
    output pout_t         pout,
    output logic          warm_boot
);
    localparam logic [TW-1:0] RST_T  = TW'(RST_MS);
    localparam logic [TW-1:0] WDOG_T = TW'(WDOG_MS);
    localparam logic [TW-1:0] WAIT_T = TW'(WAIT_MS);

    pstate_t    nxt;
    logic [1:0] target;
    logic       wake;

    assign wake = turn_on & bp_ok;
    assign pout = decode_out(cur, ccfg);

    always_comb begin
        nxt = cur;
        case (cur)
            PS_OFF:     if (wake) nxt = PS_COLD;
            PS_COLD,
            PS_WARM:    if (all_up && elapsed >= RST_T) nxt = PS_WDOG;
            PS_WDOG:    if (elapsed >= WDOG_T) nxt = PS_ON;
            PS_ON:      if (!wdi) nxt = lp_dest(target);
                        else if (uoff_req) nxt = PS_UOWAIT;
            PS_UOWAIT:  if (elapsed >= WAIT_T) nxt = lp_dest(target);
            PS_MEMHOLD: if (wake) nxt = PS_COLD;
            PS_USEROFF: if (wake) nxt = PS_WARM;
            default:    nxt = PS_OFF;
        endcase
    end

    assign restart = (nxt != cur);

    always_ff @(posedge clk) begin
        if (rst) begin
            cur       <= PS_OFF;
            target    <= 2'd0;
            warm_boot <= 1'b0;
        end else begin
            cur <= nxt;
            if (is_ramp(cur))
                target <= 2'd0;
            else if (lp_wr && pout.spi_en)
                target <= lp_code;
            if (cur == PS_MEMHOLD && nxt == PS_COLD)
                warm_boot <= 1'b1;
            else if (wb_clr && pout.spi_en)
                warm_boot <= 1'b0;
        end
    end

    // R2
    off_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cur) == PS_OFF && cur == PS_COLD) |-> $past(bp_ok));
    // R4
    wdog_entry_chk: assert property (@(posedge clk) disable iff (rst)
        (cur == PS_WDOG && $past(cur) != PS_WDOG && !$past(rst)) |-> $past(elapsed) >= RST_T);
    // R10
    useroff_wake_chk: assert property (@(posedge clk) disable iff (rst)
        ($past(cur) == PS_USEROFF && cur != PS_USEROFF && !$past(rst)) |-> cur == PS_WARM);
    // R9
    wb_set_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(warm_boot) |-> $past(cur) == PS_MEMHOLD);
endmodule

// File: rtl/pwr_mode_seq.sv
module pwr_mode_seq
    import pms_pkg::*;
#(
    parameter int NREG    = 4,
    parameter int INIT_MS = 8,
    parameter int STEP_MS = 1,
    parameter int RST_MS  = 12,
    parameter int WDOG_MS = 16,
    parameter int WAIT_MS = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            ms_tick,
    input  logic            turn_on,
    input  logic            bp_ok,
    input  logic            wdi,
    input  logic [1:0]      stby,
    input  logic            spi_uoff_req,
    input  logic            spi_lp_wr,
    input  logic [1:0]      spi_lp_code,
    input  logic            spi_wb_clr,
    input  logic            cfg_mcuclk_en,
    input  logic            cfg_uoffclk,
    input  logic            cfg_drm,
    output logic            rst_sys_n,
    output logic            rst_mcu_n,
    output logic            spi_en,
    output logic            int_pass,
    output logic            clk32_per_en,
    output logic            clk32_mcu_en,
    output logic [NREG-1:0] reg_en,
    output logic            warm_boot
);
    localparam int LAST_UP = INIT_MS + (NREG - 1) * STEP_MS;
    localparam int MAX_A   = (RST_MS > WDOG_MS) ? RST_MS : WDOG_MS;
    localparam int MAX_B   = (WAIT_MS > LAST_UP) ? WAIT_MS : LAST_UP;
    localparam int MAX_T   = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int TW      = $clog2(MAX_T + 2);

    pstate_t       cur;
    pout_t         pout;
    clkcfg_t       ccfg;
    logic          restart;
    logic          all_up;
    logic [TW-1:0] elapsed;
    logic          stby_unused;

    assign ccfg        = '{mcu_en: cfg_mcuclk_en, uoff_clk: cfg_uoffclk, drm: cfg_drm};
    assign stby_unused = ^stby;

    pms_timer #(.TW(TW)) u_timer (
        .clk(clk), .rst(rst), .restart(restart),
        .run(is_timed(cur)), .tick(ms_tick), .elapsed(elapsed)
    );

    pms_stagger #(.NREG(NREG), .INIT_MS(INIT_MS), .STEP_MS(STEP_MS), .TW(TW)) u_stagger (
        .clk(clk), .rst(rst), .ramp(is_ramp(cur)), .powered(is_powered(cur)),
        .elapsed(elapsed), .reg_en(reg_en), .all_up(all_up)
    );

    pms_fsm #(.TW(TW), .RST_MS(RST_MS), .WDOG_MS(WDOG_MS), .WAIT_MS(WAIT_MS)) u_fsm (
        .clk(clk), .rst(rst), .turn_on(turn_on), .bp_ok(bp_ok), .wdi(wdi),
        .uoff_req(spi_uoff_req), .lp_wr(spi_lp_wr), .lp_code(spi_lp_code),
        .wb_clr(spi_wb_clr), .ccfg(ccfg), .elapsed(elapsed), .all_up(all_up),
        .cur(cur), .restart(restart), .pout(pout), .warm_boot(warm_boot)
    );

    assign rst_sys_n    = pout.rst_sys_n;
    assign rst_mcu_n    = pout.rst_mcu_n;
    assign spi_en       = pout.spi_en;
    assign int_pass     = pout.int_pass;
    assign clk32_per_en = pout.clk_per;
    assign clk32_mcu_en = pout.clk_mcu;

    // R12
    idle_timer_chk: assert property (@(posedge clk) disable iff (rst)
        (cur inside {PS_OFF, PS_MEMHOLD, PS_USEROFF}) |-> elapsed == '0);
    // R8
    spi_gate_chk: assert property (@(posedge clk) disable iff (rst)
        spi_en |-> (rst_sys_n && reg_en == {NREG{1'b1}}));
endmodule

// File: tb/pwr_mode_seq_test.sv
`timescale 1ns/1ps
module pwr_mode_seq_test;
    localparam int NREG = 4, INIT_MS = 8, STEP_MS = 1, RST_MS = 12, WDOG_MS = 16, WAIT_MS = 8;
    localparam int S_OFF = 0, S_COLD = 1, S_WDOG = 2, S_ON = 3, S_UOW = 4, S_MEM = 5, S_UOFF = 6, S_WARM = 7;

    logic clk = 1'b0, rst = 1'b1, ms_tick = 0, turn_on = 0, bp_ok = 0, wdi = 1;
    logic [1:0] stby = 0, spi_lp_code = 0;
    logic spi_uoff_req = 0, spi_lp_wr = 0, spi_wb_clr = 0;
    logic cfg_mcuclk_en = 0, cfg_uoffclk = 0, cfg_drm = 0;
    logic rst_sys_n, rst_mcu_n, spi_en, int_pass, clk32_per_en, clk32_mcu_en, warm_boot;
    logic [NREG-1:0] reg_en;

    int n_chk = 0, n_fail = 0;
    int m_st = S_OFF, m_el = 0, m_tgt = 0;
    logic m_wb = 0;

    always #5 clk = ~clk;

    pwr_mode_seq uut (
        .clk(clk), .rst(rst), .ms_tick(ms_tick), .turn_on(turn_on), .bp_ok(bp_ok),
        .wdi(wdi), .stby(stby), .spi_uoff_req(spi_uoff_req), .spi_lp_wr(spi_lp_wr),
        .spi_lp_code(spi_lp_code), .spi_wb_clr(spi_wb_clr), .cfg_mcuclk_en(cfg_mcuclk_en),
        .cfg_uoffclk(cfg_uoffclk), .cfg_drm(cfg_drm), .rst_sys_n(rst_sys_n),
        .rst_mcu_n(rst_mcu_n), .spi_en(spi_en), .int_pass(int_pass),
        .clk32_per_en(clk32_per_en), .clk32_mcu_en(clk32_mcu_en), .reg_en(reg_en),
        .warm_boot(warm_boot)
    );

    function automatic logic powered(int s);
        return s == S_WDOG || s == S_ON || s == S_UOW;
    endfunction
    function automatic logic ramping(int s);
        return s == S_COLD || s == S_WARM;
    endfunction
    function automatic int dest(int code);
        return code == 1 ? S_MEM : (code == 2 ? S_UOFF : S_OFF);
    endfunction
    function automatic logic [NREG-1:0] exp_reg(int s, int el);
        logic [NREG-1:0] v = '0;
        for (int k = 0; k < NREG; k++)
            v[k] = powered(s) || (ramping(s) && el >= INIT_MS + k * STEP_MS);
        return v;
    endfunction

    task automatic chk(input string ctx, input string what, input int got, input int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", ctx, what, got, exp);
        end
    endtask

    // Reference step at the clock edge, from the requirements.
    task automatic model_edge();
        int nx;
        logic wake, spi;
        if (rst) begin
            m_st = S_OFF; m_el = 0; m_tgt = 0; m_wb = 0;
            return;
        end
        wake = turn_on && bp_ok;
        spi  = powered(m_st);
        nx   = m_st;
        case (m_st)
            S_OFF:  if (wake) nx = S_COLD;
            S_COLD, S_WARM:
                    if (m_el >= INIT_MS + (NREG - 1) * STEP_MS && m_el >= RST_MS) nx = S_WDOG;
            S_WDOG: if (m_el >= WDOG_MS) nx = S_ON;
            S_ON:   if (!wdi) nx = dest(m_tgt); else if (spi_uoff_req) nx = S_UOW;
            S_UOW:  if (m_el >= WAIT_MS) nx = dest(m_tgt);
            S_MEM:  if (wake) nx = S_COLD;
            default: if (wake) nx = S_WARM;
        endcase
        if (ramping(m_st)) m_tgt = 0;
        else if (spi_lp_wr && spi) m_tgt = int'(spi_lp_code);
        if (m_st == S_MEM && nx == S_COLD) m_wb = 1;
        else if (spi_wb_clr && spi) m_wb = 0;
        if (nx != m_st) m_el = 0;
        else if (ms_tick && (ramping(m_st) || m_st == S_WDOG || m_st == S_UOW)) m_el++;
        m_st = nx;
    endtask

    task automatic compare_all(input string ctx);
        logic pw, keep, cm;
        pw   = powered(m_st);
        keep = (cfg_mcuclk_en && cfg_uoffclk) || cfg_drm;
        cm   = pw || (m_st == S_MEM && cfg_drm) || ((m_st == S_UOFF || m_st == S_WARM) && keep);
        chk(ctx, "rst_sys_n R1 R4 R9 R10", 32'(rst_sys_n), 32'(pw));
        chk(ctx, "rst_mcu_n R4 R10", 32'(rst_mcu_n), 32'(pw || m_st == S_UOFF || m_st == S_WARM));
        chk(ctx, "spi_en R8", 32'(spi_en), 32'(pw));
        chk(ctx, "int_pass R8", 32'(int_pass), 32'(m_st == S_WDOG || m_st == S_ON));
        chk(ctx, "clk32_per_en R9", 32'(clk32_per_en), 32'(pw));
        chk(ctx, "clk32_mcu_en R10", 32'(clk32_mcu_en), 32'(cm));
        chk(ctx, "reg_en R3", 32'(reg_en), 32'(exp_reg(m_st, m_el)));
        chk(ctx, "warm_boot R11", 32'(warm_boot), 32'(m_wb));
    endtask

    task automatic run(input int n, input string ctx);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_edge();
            @(negedge clk);
            compare_all(ctx);
        end
    endtask

    task automatic pulse_wr(input logic [1:0] code, input string ctx);
        spi_lp_wr = 1; spi_lp_code = code; run(1, ctx);
        spi_lp_wr = 0;
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);
        run(2, "R1");
        rst = 0;
        run(2, "R1");
        turn_on = 1; bp_ok = 0; run(4, "R2"); turn_on = 0;
        bp_ok = 1; ms_tick = 1; run(5, "R12"); ms_tick = 0;
        turn_on = 1; run(1, "R2"); turn_on = 0;
        wdi = 0; stby = 3; ms_tick = 1; run(14, "R4 R3 R12");
        run(10, "R5"); wdi = 1; stby = 0; run(10, "R5"); ms_tick = 0;
        run(2, "R6");
        pulse_wr(2'd1, "R7");
        spi_uoff_req = 1; run(1, "R6"); spi_uoff_req = 0;
        wdi = 0; ms_tick = 1; run(10, "R7"); ms_tick = 0;
        for (int c = 0; c < 8; c++) begin
            {cfg_mcuclk_en, cfg_uoffclk, cfg_drm} = 3'(c); run(1, "R9");
        end
        turn_on = 1; run(1, "R9"); turn_on = 0;
        spi_wb_clr = 1; run(2, "R11"); spi_wb_clr = 0;
        wdi = 1; ms_tick = 1; run(32, "R4 R5"); ms_tick = 0;
        spi_wb_clr = 1; run(1, "R11"); spi_wb_clr = 0; run(1, "R11");
        pulse_wr(2'd2, "R7");
        wdi = 0; run(2, "R6");
        for (int c = 0; c < 8; c++) begin
            {cfg_mcuclk_en, cfg_uoffclk, cfg_drm} = 3'(c); run(1, "R10");
        end
        cfg_mcuclk_en = 1; cfg_uoffclk = 1; cfg_drm = 0;
        turn_on = 1; run(1, "R10"); turn_on = 0;
        ms_tick = 1; stby = 2; run(16, "R4 R10"); wdi = 1; run(20, "R5"); ms_tick = 0;
        pulse_wr(2'd3, "R7");
        spi_uoff_req = 1; run(1, "R6"); spi_uoff_req = 0;
        wdi = 0; ms_tick = 1; run(10, "R7"); ms_tick = 0;
        for (int i = 0; i < 20000; i++) begin
            ms_tick       = ($urandom % 2) == 0;
            turn_on       = ($urandom % 8) == 0;
            bp_ok         = ($urandom % 8) != 0;
            wdi           = ($urandom % 64) != 0;
            stby          = 2'($urandom);
            spi_uoff_req  = ($urandom % 32) == 0;
            spi_lp_wr     = ($urandom % 8) == 0;
            spi_lp_code   = 2'($urandom);
            spi_wb_clr    = ($urandom % 16) == 0;
            cfg_mcuclk_en = ($urandom % 2) == 0;
            cfg_uoffclk   = ($urandom % 2) == 0;
            cfg_drm       = ($urandom % 4) == 0;
            run(1, "random R2 R3 R6 R7 R11");
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule